// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small 8-bit processing core. It holds an accumulator, an index register, a 16-bit program counter, an operand buffer, and zero and carry flags. It runs a five-instruction set. Each instruction starts by reading its opcode. One-byte instructions then go straight to an execute step. Two-byte instructions first read one operand byte, and the store instruction then also writes memory.

All memory traffic goes through a single request/acknowledge port that faces an external bus cycle sequencer. The core raises a request with an address, a direction and write data, and holds all of them until the sequencer returns done. On reads, the sequencer returns the data in the same cycle as done. The architected registers are brought out on observation ports so that the surrounding logic can see them.

Top module: `acc_core`

## Requirements
- R1: While reset is low, and after it is released, A, X, zero, carry and the program counter are all 0 and no request is raised. The first access after reset is an opcode read at address 0000h.
- R2: Every instruction begins with a read at the program counter. Two-byte instructions follow it with a read at program counter + 1 to get the operand. No other accesses occur except the store write of R5.
- R3: Opcode E8h adds one to X, and FFh wraps to 00h. Zero and carry are both set when the new X is 0, and both are cleared otherwise. A is unchanged.
- R4: Opcode A9h loads the operand byte into A. It sets zero when that byte is 0 and clears zero otherwise. Carry and X are unchanged.
- R5: Opcode 85h writes A to address {00h, operand}, with the upper address byte always zero. A, X and both flags are unchanged.
- R6: Opcode 69h sets A to the low 8 bits of A + operand + carry. Carry is set when that sum exceeds 255, and zero is set when the new A is 0. Each flag is cleared otherwise.
- R7: Opcode 18h clears carry and leaves A, X and zero unchanged.
- R8: Any other opcode is a one-byte instruction with no effect on A, X or the flags.
- R9: When an instruction completes, the program counter has advanced by 1 for one-byte opcodes and by 2 for opcodes A9h, 85h and 69h.
- R10: Once raised, a request keeps its address, direction and write data stable until the cycle in which done is high. Each done completes exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data (accumulator) |
| mem_done | input | 1 | Sequencer completes the current access this cycle |
| mem_rdata | input | 8 | Read data, valid with mem_done on reads |
| obs_a | output | 8 | Accumulator value |
| obs_x | output | 8 | Index register value |
| obs_pc | output | 16 | Program counter value |
| obs_zero | output | 1 | Zero flag |
| obs_carry | output | 1 | Carry flag |

## Verification
The program begins with 256 consecutive increments. This drives X through every value and shows whether the flags are set only on the step that wraps to zero. It then runs a set of add, load and store sequences. Some of these chain a carry across a load into a second add, which separates "load keeps carry" from "load clears carry". Others add with a carry in that reaches exactly 256, which tells apart the carry test from the zero test. Unknown opcodes and clear-carry are mixed in to show what each leaves untouched. The sequencer answers with latencies that rotate from 0 to 3 cycles, so both the immediate-done path and the held-request path are covered on reads and writes.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int unsigned OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_INX = 8'hE8;
  localparam logic [OPC_W-1:0] OPC_LDI = 8'hA9;
  localparam logic [OPC_W-1:0] OPC_STZ = 8'h85;
  localparam logic [OPC_W-1:0] OPC_ADI = 8'h69;
  localparam logic [OPC_W-1:0] OPC_CLC = 8'h18;

  typedef enum logic [2:0] {
    CLS_NOP,
    CLS_INX,
    CLS_LDI,
    CLS_STZ,
    CLS_ADI,
    CLS_CLC
  } op_cls_e;

  typedef struct packed {
    op_cls_e cls;
    logic    has_opnd;
    logic    is_store;
  } dec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_OPND,
    ST_STORE,
    ST_EXEC
  } state_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] opcode,
  output dec_t              dec
);

  always_comb begin
    dec.cls      = CLS_NOP;
    dec.has_opnd = 1'b0;
    dec.is_store = 1'b0;
    if (opcode == DATA_W'(OPC_INX)) begin
      dec.cls = CLS_INX;
    end else if (opcode == DATA_W'(OPC_LDI)) begin
      dec.cls      = CLS_LDI;
      dec.has_opnd = 1'b1;
    end else if (opcode == DATA_W'(OPC_STZ)) begin
      dec.cls      = CLS_STZ;
      dec.has_opnd = 1'b1;
      dec.is_store = 1'b1;
    end else if (opcode == DATA_W'(OPC_ADI)) begin
      dec.cls      = CLS_ADI;
      dec.has_opnd = 1'b1;
    end else if (opcode == DATA_W'(OPC_CLC)) begin
      dec.cls = CLS_CLC;
    end
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  op_cls_e           exec_cls,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] idx_q,
  output logic              zf_q,
  output logic              cf_q
);

  localparam int unsigned SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] acc_d, idx_d, idx_inc;
  logic              zf_d, cf_d;
  logic [SUM_W-1:0]  sum;

  assign idx_inc = idx_q + 1'b1;
  assign sum     = {1'b0, acc_q} + {1'b0, opnd} + SUM_W'(cf_q);

  always_comb begin
    acc_d = acc_q;
    idx_d = idx_q;
    zf_d  = zf_q;
    cf_d  = cf_q;
    case (exec_cls)
      CLS_INX: begin
        idx_d = idx_inc;
        zf_d  = (idx_inc == '0);
        cf_d  = (idx_inc == '0);
      end
      CLS_LDI: begin
        acc_d = opnd;
        zf_d  = (opnd == '0);
      end
      CLS_ADI: begin
        acc_d = sum[DATA_W-1:0];
        cf_d  = sum[DATA_W];
        zf_d  = (sum[DATA_W-1:0] == '0);
      end
      CLS_CLC: cf_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
      zf_q  <= 1'b0;
      cf_q  <= 1'b0;
    end else if (exec_en) begin
      acc_q <= acc_d;
      idx_q <= idx_d;
      zf_q  <= zf_d;
      cf_q  <= cf_d;
    end
  end

  // R3: wrap of X sets both flags
  p_inx_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && exec_cls == CLS_INX && idx_q == '1 |=> idx_q == '0 && zf_q && cf_q);

  // R3: non-wrapping increment clears both flags
  p_inx_nowrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && exec_cls == CLS_INX && idx_q != '1 |=> !zf_q && !cf_q && $stable(acc_q));

  // R4: load leaves carry alone
  p_lda_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && exec_cls == CLS_LDI |=> $stable(cf_q) && $stable(idx_q));

  // R7: clear carry touches nothing else
  p_clc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && exec_cls == CLS_CLC |=> !cf_q && $stable(acc_q) && $stable(zf_q));

  // R8: unknown opcode changes nothing
  p_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && exec_cls == CLS_NOP |=>
      $stable(acc_q) && $stable(idx_q) && $stable(zf_q) && $stable(cf_q));

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] acc_val,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              exec_en,
  output op_cls_e           exec_cls,
  output logic [DATA_W-1:0] opnd,
  output logic [ADDR_W-1:0] pc
);

  localparam int unsigned PAGE_W = ADDR_W - DATA_W;

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] ir_q, ir_d, mbr_q, mbr_d;
  logic              pc_en, ir_en, mbr_en;
  dec_t              dec;

  acc_decode #(.DATA_W(DATA_W)) u_dec (
    .opcode (ir_q),
    .dec    (dec)
  );

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ir_d      = ir_q;
    mbr_d     = mbr_q;
    pc_en     = 1'b0;
    ir_en     = 1'b0;
    mbr_en    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = acc_val;
    exec_en   = 1'b0;
    case (state_q)
      ST_IDLE: state_d = ST_FETCH;
      ST_FETCH: begin
        mem_req = 1'b1;
        if (mem_done) begin
          ir_d    = mem_rdata;
          ir_en   = 1'b1;
          state_d = ST_DECODE;
        end
      end
      ST_DECODE: state_d = dec.has_opnd ? ST_OPND : ST_EXEC;
      ST_OPND: begin
        mem_req  = 1'b1;
        mem_addr = pc_q + 1'b1;
        if (mem_done) begin
          mbr_d   = mem_rdata;
          mbr_en  = 1'b1;
          state_d = dec.is_store ? ST_STORE : ST_EXEC;
        end
      end
      ST_STORE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {{PAGE_W{1'b0}}, mbr_q};
        if (mem_done) state_d = ST_EXEC;
      end
      ST_EXEC: begin
        exec_en = 1'b1;
        pc_en   = 1'b1;
        pc_d    = pc_q + (dec.has_opnd ? ADDR_W'(2) : ADDR_W'(1));
        state_d = ST_FETCH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ir_q    <= '0;
      mbr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= ir_d;
      if (mbr_en) mbr_q <= mbr_d;
    end
  end

  assign exec_cls = dec.cls;
  assign opnd     = mbr_q;
  assign pc       = pc_q;

  // R10: request is held steady until done
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R5: writes stay in page zero
  p_store_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[ADDR_W-1:DATA_W] == '0);

  // R9: one-byte instructions step by one
  p_pc_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && !dec.has_opnd |=> pc_q == $past(pc_q) + 1'b1);

  // R9: two-byte instructions step by two
  p_pc_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && dec.has_opnd |=> pc_q == $past(pc_q) + ADDR_W'(2));

  // R1: nothing is requested in the cycle right after reset release
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> !mem_req && pc_q == '0);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] obs_a,
  output logic [DATA_W-1:0] obs_x,
  output logic [ADDR_W-1:0] obs_pc,
  output logic              obs_zero,
  output logic              obs_carry
);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_int_n;

  generate
    if (RST_STAGES == 1) begin : g_rst_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_rst_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_pipe[RST_STAGES-1];

  logic              exec_en;
  op_cls_e           exec_cls;
  logic [DATA_W-1:0] opnd, acc_q;

  acc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mem_done  (mem_done),
    .mem_rdata (mem_rdata),
    .acc_val   (acc_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .exec_en   (exec_en),
    .exec_cls  (exec_cls),
    .opnd      (opnd),
    .pc        (obs_pc)
  );

  acc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .exec_en  (exec_en),
    .exec_cls (exec_cls),
    .opnd     (opnd),
    .acc_q    (acc_q),
    .idx_q    (obs_x),
    .zf_q     (obs_zero),
    .cf_q     (obs_carry)
  );

  assign obs_a = acc_q;

  // R10: a write always carries the accumulator
  p_wdata_acc_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req && mem_we |-> mem_wdata == obs_a);

endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_req, mem_we, mem_done;
  logic [15:0] mem_addr, obs_pc;
  logic [7:0]  mem_wdata, mem_rdata, obs_a, obs_x;
  logic        obs_zero, obs_carry;

  always #2 clk = ~clk;

  acc_core u0 (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_done(mem_done), .mem_rdata(mem_rdata),
    .obs_a(obs_a), .obs_x(obs_x), .obs_pc(obs_pc), .obs_zero(obs_zero), .obs_carry(obs_carry)
  );

  logic [7:0] mem [0:1023];
  int n_chk = 0, n_err = 0;
  int m_a, m_x, m_z, m_c, m_pc;
  int q_addr[$], q_we[$], q_wd[$];
  string q_tag[$];
  string prev_tag;
  int n_prog, p;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(int b);
    mem[p] = 8'(b);
    p++;
  endtask

  task automatic push(int a, int we, int wd, string t);
    q_addr.push_back(a); q_we.push_back(we); q_wd.push_back(wd); q_tag.push_back(t);
  endtask

  // behavioural instruction model: expected accesses and resulting state
  task automatic predict();
    int op, o, s;
    op = int'(mem[m_pc & 1023]);
    o  = int'(mem[(m_pc + 1) & 1023]);
    push(m_pc, 0, 0, "R2 fetch");
    case (op)
      'hE8: begin m_x = (m_x + 1) & 255; m_z = (m_x == 0); m_c = m_z; m_pc += 1; prev_tag = "R3"; end
      'hA9: begin push(m_pc + 1, 0, 0, "R2 operand"); m_a = o; m_z = (o == 0); m_pc += 2; prev_tag = "R4"; end
      'h85: begin push(m_pc + 1, 0, 0, "R2 operand"); push(o, 1, m_a, "R5 store"); m_pc += 2; prev_tag = "R5"; end
      'h69: begin
        push(m_pc + 1, 0, 0, "R2 operand");
        s = m_a + o + m_c; m_c = (s > 255); m_a = s & 255; m_z = (m_a == 0);
        m_pc += 2; prev_tag = "R6";
      end
      'h18: begin m_c = 0; m_pc += 1; prev_tag = "R7"; end
      default: begin m_pc += 1; prev_tag = "R8"; end
    endcase
  endtask

  initial begin
    bit busy, finished;
    int waitc, lat, ninstr, cyc;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    p = 0;
    for (int i = 0; i < 256; i++) put('hE8);   // X walks through every value
    n_prog = 256;
    put('h18);                n_prog++;       // clear carry
    put('hA9); put('h00);     n_prog++;       // load zero
    put('hA9); put('h07);     n_prog++;
    put('h85); put('h20);     n_prog++;
    put('h69); put('h28);     n_prog++;       // 7+40
    put('h85); put('h21);     n_prog++;
    put('hA9); put('hFF);     n_prog++;
    put('h69); put('h01);     n_prog++;       // wraps: A=0, C=1
    put('h69); put('hFF);     n_prog++;       // 0+FF+1 = 256 exactly
    put('h69); put('h05);     n_prog++;       // carry in used
    put('hE8);                n_prog++;       // X 0->1 clears flags
    put('hA9); put('hF0);     n_prog++;
    put('h69); put('h20);     n_prog++;       // low byte carry out
    put('hA9); put('h01);     n_prog++;       // load keeps carry
    put('h69); put('h00);     n_prog++;       // carry chained
    put('h85); put('h22);     n_prog++;
    put('h38);                n_prog++;       // unknown opcode
    put('hA9); put('hFF);     n_prog++;
    put('h69); put('hFF);     n_prog++;
    put('h00);                n_prog++;       // unknown, carry stays set
    put('h18);                n_prog++;
    put('h69); put('h01);     n_prog++;
    put('h85); put('hFF);     n_prog++;

    m_a = 0; m_x = 0; m_z = 0; m_c = 0; m_pc = 0; prev_tag = "R1";
    rst_n = 1'b0; mem_done = 1'b0; mem_rdata = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "req in reset", 32'(mem_req), 0);
    chk("R1", "A in reset", 32'(obs_a), 0);
    chk("R1", "X in reset", 32'(obs_x), 0);
    chk("R1", "PC in reset", 32'(obs_pc), 0);
    chk("R1", "flags in reset", {obs_zero, obs_carry}, 0);
    rst_n = 1'b1;

    busy = 0; waitc = 0; lat = 0; ninstr = 0; cyc = 0; finished = 0;
    while (!finished) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_err++;
        $display("FAIL R10 watchdog: actual=hung expected=progress");
        finished = 1;
      end else if (mem_req) begin
        if (!busy) begin
          if (q_addr.size() == 0) begin
            chk(prev_tag, "A", 32'(obs_a), 32'(m_a));
            chk(prev_tag, "X", 32'(obs_x), 32'(m_x));
            chk(prev_tag, "zero", 32'(obs_zero), 32'(m_z));
            chk(prev_tag, "carry", 32'(obs_carry), 32'(m_c));
            chk("R9", "PC", 32'(obs_pc), 32'(m_pc));
            if (ninstr == n_prog) finished = 1;
            else begin predict(); ninstr++; end
          end
          if (!finished) begin
            chk(q_tag[0], "addr", 32'(mem_addr), 32'(q_addr[0]));
            chk(q_tag[0], "dir", 32'(mem_we), 32'(q_we[0]));
            if (q_we[0] == 1) chk(q_tag[0], "wdata", 32'(mem_wdata), 32'(q_wd[0]));
            busy = 1; waitc = 0;
          end
        end else begin
          chk("R10", "held addr", 32'(mem_addr), 32'(q_addr[0]));
          chk("R10", "held dir", 32'(mem_we), 32'(q_we[0]));
        end
        if (!finished) begin
          if (waitc == lat) begin
            mem_done = 1'b1;
            mem_rdata = mem[mem_addr & 16'h03FF];
            if (mem_we) mem[mem_addr & 16'h03FF] = mem_wdata;
            void'(q_addr.pop_front()); void'(q_we.pop_front());
            void'(q_wd.pop_front()); void'(q_tag.pop_front());
            busy = 0; lat = (lat + 1) % 4;
          end else begin
            mem_done = 1'b0; waitc++;
          end
        end
      end else begin
        mem_done = 1'b0;
        if (busy) chk("R10", "request dropped", 0, 1);
      end
    end
    chk("R5", "stored 7", 32'(mem[16'h20]), 32'h07);
    chk("R5", "stored 2F", 32'(mem[16'h21]), 32'h2F);
    chk("R6", "chained sum", 32'(mem[16'h22]), 32'h02);
    chk("R5", "stored at page top", 32'(mem[16'hFF]), 32'hFF);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule